// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits on the controller side of an 8-bit small-page NAND flash bus. A host asks for one of three operations with a single-cycle start pulse: a page read, a page program or a block erase. It gives a column byte and a row address with the request. The sequencer then drives chip enable, the two latch enables, the write and read strobes, write protect and the data bus. It emits the command, address and data cycles that the operation needs. It then waits on the ready/busy line and finishes with a one-cycle done pulse, which carries an error flag if the device stayed busy too long.

Page data moves one byte at a time. On a program, the host holds the next byte on `wr_data` and advances it after each `wr_take` pulse. On a read, every byte fetched from the device appears on `rd_data` with a one-cycle `rd_valid`. Strobe low and high widths are a whole number of system clocks set by `STROBE`. The number of row address cycles is chosen for each request, so small and large densities share one engine.

Top module: `nand_seq`

## Requirements
- R1: When `op`=0 (read), the bus carries command 00h, the column byte, then the row bytes from least significant upward. The block waits for ready/busy high, then gives `PAGE_BYTES` read-strobe pulses. Each byte sampled from `nand_dq_i` comes out on `rd_data` with `rd_valid`, in order.
- R2: When `op`=1 (program), the bus carries command 80h, the column byte, the row bytes, then `PAGE_BYTES` data bytes. Each data byte is the `wr_data` value present at that byte; one `wr_take` pulse follows each byte. Then comes command 10h, and a busy wait follows.
- R3: When `op`=2 (erase), the bus carries command 60h, then only the row bytes (no column byte), then command D0h, and a busy wait follows.
- R4: With `four_cyc`=0 two row bytes are sent (row[15:0]). With `four_cyc`=1 three are sent (row[23:0]), giving 3 or 4 address cycles on read and program.
- R5: Command bytes are latched with `nand_cle`=1 and `nand_ale`=0, address bytes with `nand_ale`=1 and `nand_cle`=0, and data with both 0. The latch happens on the rising edge of `nand_we_n` while `nand_ce_n`=0. The two latch enables are never high together.
- R6: Each write or read strobe stays low for exactly `STROBE` clocks, and consecutive strobes are separated by at least `STROBE` high clocks.
- R7: `nand_dq_oe` is high only during command, address and write-data cycles, never while `nand_re_n` is low and never while `nand_ce_n` is high.
- R8: Ready/busy is not sampled for the first `GAP` clocks of a wait. `done` without error and read strobes occur only after ready/busy has returned high.
- R9: If a wait lasts `TIMEOUT` clocks without ready/busy high, `done` and `err` pulse together. No read strobes follow, and the block returns to idle.
- R10: When idle, `nand_ce_n`=1, both strobes are high, `nand_wp_n`=0 and `done`=0. A `start` while busy, or with `op`=3, is ignored.
- R11: `nand_wp_n` is high whenever `nand_ce_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request pulse |
| op | input | 2 | 0 read, 1 program, 2 erase, 3 ignored |
| col | input | 8 | Column byte |
| row | input | 24 | Row (page/block) address |
| four_cyc | input | 1 | 1 selects three row bytes |
| wr_data | input | 8 | Current program byte |
| wr_take | output | 1 | Program byte consumed |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | `rd_data` valid |
| done | output | 1 | Operation finished |
| err | output | 1 | Busy timeout, with `done` |
| nand_ce_n | output | 1 | Chip enable, low active |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe |
| nand_re_n | output | 1 | Read strobe |
| nand_wp_n | output | 1 | Write protect, low active |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb | input | 1 | Ready (1) / busy (0) |

## Verification
The bench builds the block with `STROBE`=2, `GAP`=3 and `TIMEOUT`=200, keeping the full 528-byte page. Strobes are then only four clocks apart, so whole pages move quickly while every width check still has a non-trivial value to see. The 200-clock limit lets a device model that holds busy for 1000 clocks hit the timeout, while random busy lengths of 5 to 104 clocks always finish in time.

// File: rtl/nand_seq.sv
module nand_seq #(
  parameter int STROBE     = 2,
  parameter int GAP        = 4,
  parameter int TIMEOUT    = 5000,
  parameter int PAGE_BYTES = 528
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [7:0]  col,
  input  logic [23:0] row,
  input  logic        four_cyc,
  input  logic [7:0]  wr_data,
  output logic        wr_take,
  output logic [7:0]  rd_data,
  output logic        rd_valid,
  output logic        done,
  output logic        err,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_wp_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb
);
  localparam int SW = $clog2(STROBE + 1);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int BW = $clog2(PAGE_BYTES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD1, S_ADDR, S_WDAT, S_CMD2, S_WAIT, S_RDAT, S_DONE} st_t;

  st_t         st;
  logic [1:0]  op_q;
  logic        four_q, err_q, ph;
  logic [7:0]  col_q;
  logic [23:0] row_q;
  logic [BW-1:0] idx;
  logic [SW-1:0] pc;
  logic [TW-1:0] wc;

  wire is_rd = (op_q == 2'd0);
  wire is_er = (op_q == 2'd2);
  wire bus_st = (st == S_CMD1) || (st == S_ADDR) || (st == S_WDAT) || (st == S_CMD2) || (st == S_RDAT);
  wire ph_end = (pc == SW'(STROBE - 1));
  wire cyc_end = bus_st && ph && ph_end;
  wire [2:0] a_last = (is_er ? 3'd1 : 3'd2) + {2'b0, four_q};
  wire [1:0] rsel = is_er ? idx[1:0] : idx[1:0] - 2'd1;
  wire last_byte = (idx == BW'(PAGE_BYTES - 1));

  logic [7:0] abyte, rbyte;
  always_comb begin
    case (rsel)
      2'd0:    rbyte = row_q[7:0];
      2'd1:    rbyte = row_q[15:8];
      default: rbyte = row_q[23:16];
    endcase
    abyte = (!is_er && idx == '0) ? col_q : rbyte;
  end

  always_comb begin
    case (st)
      S_CMD1:  nand_dq_o = is_rd ? 8'h00 : (is_er ? 8'h60 : 8'h80);
      S_CMD2:  nand_dq_o = is_er ? 8'hD0 : 8'h10;
      S_ADDR:  nand_dq_o = abyte;
      S_WDAT:  nand_dq_o = wr_data;
      default: nand_dq_o = 8'h00;
    endcase
  end

  assign nand_ce_n  = (st == S_IDLE);
  assign nand_wp_n  = (st != S_IDLE);
  assign nand_cle   = (st == S_CMD1) || (st == S_CMD2);
  assign nand_ale   = (st == S_ADDR);
  assign nand_dq_oe = nand_cle || nand_ale || (st == S_WDAT);
  assign nand_we_n  = !(nand_dq_oe && !ph);
  assign nand_re_n  = !((st == S_RDAT) && !ph);
  assign wr_take    = (st == S_WDAT) && cyc_end;
  assign done       = (st == S_DONE);
  assign err        = done && err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= '0; four_q <= 1'b0; err_q <= 1'b0; ph <= 1'b0;
      col_q <= '0; row_q <= '0; idx <= '0; pc <= '0; wc <= '0;
      rd_data <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (bus_st) begin
        pc <= ph_end ? '0 : pc + 1'b1;
        if (ph_end) ph <= !ph;
      end
      if (st == S_RDAT && !ph && ph_end) begin
        rd_data <= nand_dq_i;
        rd_valid <= 1'b1;
      end
      case (st)
        S_IDLE: if (start && op != 2'd3) begin
          st <= S_CMD1; op_q <= op; four_q <= four_cyc; col_q <= col; row_q <= row;
          err_q <= 1'b0; idx <= '0; pc <= '0; ph <= 1'b0; wc <= '0;
        end
        S_CMD1: if (cyc_end) st <= S_ADDR;
        S_ADDR: if (cyc_end) begin
          if (idx == BW'(a_last)) begin
            idx <= '0;
            st <= is_rd ? S_WAIT : (is_er ? S_CMD2 : S_WDAT);
          end else idx <= idx + 1'b1;
        end
        S_WDAT: if (cyc_end) begin
          if (last_byte) st <= S_CMD2;
          else idx <= idx + 1'b1;
        end
        S_CMD2: if (cyc_end) st <= S_WAIT;
        S_WAIT: begin
          wc <= wc + 1'b1;
          if (wc >= TW'(GAP) && nand_rb) begin
            st <= is_rd ? S_RDAT : S_DONE;
            idx <= '0; pc <= '0; ph <= 1'b0;
          end else if (wc == TW'(TIMEOUT - 1)) begin
            err_q <= 1'b1;
            st <= S_DONE;
          end
        end
        S_RDAT: if (cyc_end) begin
          if (last_byte) st <= S_DONE;
          else idx <= idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_latch_excl_R5: assert property (@(posedge clk) disable iff (!rst_n) !(nand_cle && nand_ale));
  assert_strobe_ce_R5: assert property (@(posedge clk) disable iff (!rst_n) (!nand_we_n || !nand_re_n) |-> !nand_ce_n);
  assert_oe_read_R7: assert property (@(posedge clk) disable iff (!rst_n) !nand_re_n |-> !nand_dq_oe);
  assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n) (done && !err) |-> $past(nand_rb));
  assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n) done |=> nand_ce_n);
endmodule

// File: tb/test_nand_seq.sv
module test_nand_seq;
  localparam int STROBE = 2, GAP = 3, TIMEOUT = 200, PAGE = 528;

  logic clk = 0, rst_n = 0, start = 0, four = 0, rb = 1;
  logic [1:0] op = 0;
  logic [7:0] col = 0, wr_data = 0, dq_i = 0;
  logic [23:0] row = 0;
  logic wr_take, rd_valid, done, err, ce_n, cle, ale, we_n, re_n, wp_n, oe;
  logic [7:0] rd_data, dq_o;

  nand_seq #(.STROBE(STROBE), .GAP(GAP), .TIMEOUT(TIMEOUT), .PAGE_BYTES(PAGE)) i_nand_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .col(col), .row(row), .four_cyc(four),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .err(err), .nand_ce_n(ce_n), .nand_cle(cle), .nand_ale(ale),
    .nand_we_n(we_n), .nand_re_n(re_n), .nand_wp_n(wp_n), .nand_dq_o(dq_o),
    .nand_dq_oe(oe), .nand_dq_i(dq_i), .nand_rb(rb));

  always #10 clk = !clk;

  int nchk = 0, nfail = 0;
  int lg[0:1023];
  int nlog, na, cur_op, cur_four, busy_len, busy_cnt, trig_cyc, done_cyc, cyc;
  int rd_idx, rd_k, wr_i, rdbad, re_pulses, ce_low;
  int v6, v7, v8, v11, lo_we, hi_we, lo_re, hi_re;
  bit done_seen, err_seen, pwe = 1, pre = 1;

  function automatic logic [7:0] wpat(int i); return 8'((i * 37 + 11) ^ (i >> 4)); endfunction
  function automatic logic [7:0] rpat(int i); return 8'((i * 91 + 5) ^ (i >> 2)); endfunction

  function automatic int exp_len(int o, int f);
    int n = ((o == 2) ? 2 : 3) + f;
    if (o == 0) return 1 + n;
    if (o == 1) return 2 + n + PAGE;
    return 2 + n;
  endfunction

  function automatic int exp_kv(int o, int c, int r, int f, int j);
    int n = ((o == 2) ? 2 : 3) + f;
    int ai, rs;
    if (j == 0) return (o == 0) ? 8'h00 : ((o == 1) ? 8'h80 : 8'h60);
    if (j <= n) begin
      ai = j - 1;
      if (o != 2 && ai == 0) return 256 + c;
      rs = (o == 2) ? ai : ai - 1;
      return 256 + ((r >> (8 * rs)) & 255);
    end
    if (o == 1 && j <= n + PAGE) return 512 + int'(wpat(j - n - 1));
    return (o == 1) ? 8'h10 : 8'hD0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!ce_n) ce_low++;
    if (busy_cnt > 0) begin busy_cnt--; if (busy_cnt == 0) rb = 1; end
    if (!we_n) lo_we++; else if (!ce_n) hi_we++; else hi_we = 0;
    if (!re_n) lo_re++; else if (!ce_n) hi_re++; else hi_re = 0;
    if (pwe && !we_n) begin if (hi_we > 0 && hi_we < STROBE) v6++; hi_we = 0; end
    if (pre && !re_n) begin if (hi_re > 0 && hi_re < STROBE) v6++; hi_re = 0; end
    if (!pwe && we_n) begin
      if (lo_we != STROBE) v6++;
      lo_we = 0;
      if (nlog < 1024) begin
        lg[nlog] = (ce_n || (cle && ale)) ? 768 + int'(dq_o) :
                   cle ? int'(dq_o) : ale ? 256 + int'(dq_o) : 512 + int'(dq_o);
        nlog++;
      end
      if (cle && (dq_o == 8'h10 || dq_o == 8'hD0)) begin rb = 0; busy_cnt = busy_len; trig_cyc = cyc; end
      if (ale && cur_op == 0) begin
        na++;
        if (na == 3 + cur_four) begin rb = 0; busy_cnt = busy_len; trig_cyc = cyc; end
      end
    end
    if (!pre && re_n) begin
      if (lo_re != STROBE) v6++;
      lo_re = 0; re_pulses++; rd_idx++; dq_i = rpat(rd_idx);
    end
    pwe = we_n; pre = re_n;
    if (rd_valid) begin if (rd_data != rpat(rd_k)) rdbad++; rd_k++; end
    if (wr_take) begin wr_i++; wr_data = wpat(wr_i); end
    if ((!re_n && oe) || (oe && ce_n)) v7++;
    if (!rb && (!re_n || (done && !err))) v8++;
    if (!ce_n && !wp_n) v11++;
    if (done && !done_seen) begin done_seen = 1; err_seen = err; done_cyc = cyc; end
  end

  task automatic run_op(input int o, input int c, input int r, input int f, input int bl, input bit rej);
    int mism = 0, nad = 0, bad5 = 0, el;
    bit to = (bl >= TIMEOUT);
    string tg = (o == 0) ? "R1" : (o == 1) ? "R2" : "R3";
    @(negedge clk);
    op = 2'(o); col = 8'(c); row = 24'(r); four = f[0]; busy_len = bl;
    cur_op = o; cur_four = f; nlog = 0; na = 0; rd_idx = 0; dq_i = rpat(0); rd_k = 0;
    wr_i = 0; wr_data = wpat(0); re_pulses = 0; rdbad = 0;
    v6 = 0; v7 = 0; v8 = 0; v11 = 0; done_seen = 0; err_seen = 0; trig_cyc = 0;
    start = 1; @(negedge clk); start = 0;
    if (rej) begin
      repeat (30) @(negedge clk);
      op = (o == 2) ? 2'd0 : 2'd2; start = 1; @(negedge clk); start = 0;
    end
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    el = exp_len(o, f);
    for (int j = 0; j < nlog; j++) begin
      if (j >= el || lg[j] != exp_kv(o, c, r, f, j)) mism++;
      if (lg[j] >= 768) bad5++;
      if (lg[j] >= 256 && lg[j] < 512) nad++;
    end
    chk(nlog == el, {tg, " cycle count", rej ? " R10 reject" : ""}, nlog, el);
    chk(mism == 0, {tg, " bus bytes"}, mism, 0);
    chk(nad == ((o == 2) ? 2 : 3) + f, "R4 address cycles", nad, ((o == 2) ? 2 : 3) + f);
    chk(bad5 == 0, "R5 latch signals", bad5, 0);
    chk(v6 == 0, "R6 strobe width", v6, 0);
    chk(v7 == 0, "R7 output enable", v7, 0);
    chk(v8 == 0, "R8 busy respected", v8, 0);
    chk(v11 == 0, "R11 write protect", v11, 0);
    chk(err_seen == to, "R9 error flag", err_seen, to);
    chk(ce_n == 1, "R10 idle after done", ce_n, 1);
    if (to) chk(re_pulses == 0, "R9 no data after timeout", re_pulses, 0);
    else chk(done_cyc - trig_cyc >= bl, "R8 wait length", done_cyc - trig_cyc, bl);
    if (o == 0 && !to) begin
      chk(rdbad == 0 && rd_k == PAGE, "R1 read data", rdbad * 10000 + rd_k, PAGE);
      chk(re_pulses == PAGE, "R1 read pulses", re_pulses, PAGE);
    end
    if (o == 1) chk(wr_i == PAGE, "R2 wr_take count", wr_i, PAGE);
    while (!rb) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ce_n && we_n && re_n && !wp_n && !done && !oe, "R10 reset state",
        {ce_n, we_n, re_n, wp_n, done, oe}, 6'b111000);
    run_op(0, 8'h12, 24'h345678, 0, 40, 0);
    run_op(0, 8'hA5, 24'hC0FFEE, 1, 17, 0);
    run_op(1, 8'h03, 24'h00BEEF, 1, 60, 0);
    run_op(2, 8'h77, 24'h1234AB, 0, 25, 0);
    run_op(2, 8'h77, 24'h9A5C31, 1, 25, 0);
    run_op(0, 8'h00, 24'h000001, 0, 1000, 0);
    run_op(1, 8'hFF, 24'hFFFFFF, 0, 30, 1);
    ce_low = 0;
    @(negedge clk); op = 2'd3; start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    chk(ce_low == 0, "R10 op 3 ignored", ce_low, 0);
    for (int k = 0; k < 6; k++)
      run_op(int'($urandom % 3), int'($urandom % 256), int'($urandom & 24'hFFFFFF),
             int'($urandom % 2), 5 + int'($urandom % 100), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule